// File: doc/BRIEF.md
# Multi-Source Event Frame Packer

The packer assembles one outgoing event record from a set of per-source data FIFOs. Each source has a frame-ready flag that says a complete frame sits in its FIFO, and the FIFO shows its head word with an end-of-frame bit beside it. When the first flag appears, the packer lets a short settling interval pass. It then waits for the remaining sources until either every flag is up or a timeout runs out, and at that point it records which sources will take part.

The record leaves on a 32-bit valid/ready stream. The first word is a begin marker, the second a header carrying a 16-bit record count, and then comes the frame of every participating source, lowest index first, each through its end-of-frame word. An end marker closes the record. A FIFO word is popped only in the cycle in which the stream accepts it, so a stalled consumer loses nothing. The packer uses no command input, so command traffic elsewhere cannot break off a record.

Top module: `evframe_packer`

## Requirements
- R1: While reset is asserted, and after it is released while no flag is raised, `rec_valid` is low and `src_pop` is all zeros.
- R2: When all flags rise in the same cycle, the begin marker is first presented (`rec_valid` high) on the sixth rising clock edge after the flags are driven. Four of those cycles are the fixed settling interval.
- R3: When some flags stay low, the begin marker is first presented on the (5 + TIMEOUT_CYC)-th rising edge after the first flag is driven. The timeout count starts when the settling interval ends.
- R4: Every record starts with BEGIN_MARK, and words are never presented outside a record.
- R5: The second word of a record is {HDR_TAG, count}, with HDR_TAG in bits 31:16 and a 16-bit count in bits 15:0. The count is 0 for the first record after reset and rises by one per record.
- R6: Participating sources are read in ascending index order. Every word of a source's frame is forwarded up to and including the word whose end-of-frame bit is set.
- R7: Only sources whose flag is high when the gather phase ends take part. A source whose flag rises later is neither popped nor forwarded in that record, and it starts a following record of its own.
- R8: `src_pop` has at most one bit set, only in a cycle with `rec_valid` and `rec_ready` both high, and only for a source whose flag is high. While `rec_valid` is high and `rec_ready` low, the next cycle keeps `rec_valid` high and `rec_data` unchanged.
- R9: END_MARK is the last word of a record and follows the last participating source's end-of-frame word. The packer then returns to waiting for flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_frame_vld | input | 20 | Per-source flag: a complete frame is queued |
| src_word_avail | input | 20 | Per-source FIFO not empty |
| src_word | input | 640 | Head words of all source FIFOs, source i in bits 32*i+31:32*i |
| src_word_eof | input | 20 | Head word of source i is the last of its frame |
| src_pop | output | 20 | Per-source pop strobe, consuming the head word |
| rec_valid | output | 1 | Record stream word valid |
| rec_ready | input | 1 | Record stream consumer ready |
| rec_data | output | 32 | Record stream word |

## Verification
The hardest case to reach is a source whose flag rises after the gather decision while a record is still being sent. That source must be left untouched in the running record and then start a record of its own, timed from the end marker rather than from its own flag. The bench waits for the first `rec_valid` of a timed-out record and only then loads a frame into a source that was idle. Its reference stream already holds both records, and the bench checks that the late FIFO is still full when the first end marker is accepted. Random backpressure runs during the data phase so that stalls land on markers, on the header and on end-of-frame words.

// File: rtl/evpack_pkg.sv
package evpack_pkg;

   typedef enum logic [2:0] {
      PK_IDLE,
      PK_SETTLE,
      PK_GATHER,
      PK_BEGIN,
      PK_HEAD,
      PK_SCAN,
      PK_END
   } pk_state_e;

   function automatic int unsigned pk_cnt_width(input int unsigned a, input int unsigned b);
      int unsigned m;
      m = (a > b) ? a : b;
      return $clog2(m + 1);
   endfunction

endpackage

// File: rtl/evpack_wait_timer.sv
module evpack_wait_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] count
);

   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (count != CNT_MAX) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/evpack_src_sel.sv
module evpack_src_sel #(
   parameter int unsigned NUM_SRC = 20,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IW      = 5
) (
   input  logic [IW-1:0]             sel,
   input  logic                      pop_en,
   input  logic [NUM_SRC*DATA_W-1:0] src_word,
   input  logic [NUM_SRC-1:0]        src_word_avail,
   input  logic [NUM_SRC-1:0]        src_word_eof,
   output logic [DATA_W-1:0]         sel_word,
   output logic                      sel_avail,
   output logic                      sel_eof,
   output logic [NUM_SRC-1:0]        src_pop
);

   always_comb begin
      sel_word  = '0;
      sel_avail = 1'b0;
      sel_eof   = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel == IW'(i)) begin
            sel_word  = src_word[i*DATA_W +: DATA_W];
            sel_avail = src_word_avail[i];
            sel_eof   = src_word_eof[i];
         end
      end
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_pop
      assign src_pop[g] = pop_en && (sel == IW'(g));
   end

endmodule

// File: rtl/evframe_packer.sv
module evframe_packer #(
   parameter int unsigned   NUM_SRC     = 20,
   parameter int unsigned   DATA_W      = 32,
   parameter int unsigned   EVT_W       = 16,
   parameter int unsigned   SETTLE_CYC  = 4,
   parameter int unsigned   TIMEOUT_CYC = 64,
   parameter logic [31:0]   BEGIN_MARK  = 32'hA5A5_0B0B,
   parameter logic [31:0]   END_MARK    = 32'h5A5A_0E0E,
   parameter logic [15:0]   HDR_TAG     = 16'hD7C3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        src_frame_vld,
   input  logic [NUM_SRC-1:0]        src_word_avail,
   input  logic [NUM_SRC*DATA_W-1:0] src_word,
   input  logic [NUM_SRC-1:0]        src_word_eof,
   output logic [NUM_SRC-1:0]        src_pop,
   input  logic                      rec_ready,
   output logic                      rec_valid,
   output logic [DATA_W-1:0]         rec_data
);

   import evpack_pkg::*;

   localparam int unsigned IW    = $clog2(NUM_SRC);
   localparam int unsigned CW    = pk_cnt_width(SETTLE_CYC, TIMEOUT_CYC);
   localparam int unsigned TAG_W = DATA_W - EVT_W;
   localparam logic [CW-1:0] SETTLE_LAST  = CW'(SETTLE_CYC - 1);
   localparam logic [CW-1:0] TIMEOUT_LAST = CW'(TIMEOUT_CYC - 1);
   localparam logic [IW-1:0] LAST_IDX     = IW'(NUM_SRC - 1);

   if (NUM_SRC < 2) begin : g_chk_src
      $error("evframe_packer: NUM_SRC must be at least 2");
   end
   if (DATA_W != 32) begin : g_chk_width
      $error("evframe_packer: DATA_W must be 32 to carry the 32-bit markers");
   end
   if (EVT_W >= DATA_W || TAG_W > 16) begin : g_chk_evt
      $error("evframe_packer: EVT_W must leave at most 16 tag bits in the header");
   end
   if (SETTLE_CYC < 1 || TIMEOUT_CYC < 1) begin : g_chk_time
      $error("evframe_packer: SETTLE_CYC and TIMEOUT_CYC must be at least 1");
   end

   pk_state_e            state_q, state_d;
   logic [IW-1:0]        idx_q, idx_d;
   logic [NUM_SRC-1:0]   mask_q, mask_d;
   logic [EVT_W-1:0]     evt_q, evt_d;
   logic [CW-1:0]        tmr_cnt;
   logic                 tmr_clr;
   logic [DATA_W-1:0]    sel_word;
   logic                 sel_avail;
   logic                 sel_eof;
   logic                 pop_en;
   logic                 all_vld;
   logic                 settle_done;
   logic                 gather_tmo;

   assign all_vld     = &src_frame_vld;
   assign settle_done = (tmr_cnt == SETTLE_LAST);
   assign gather_tmo  = (tmr_cnt == TIMEOUT_LAST);
   assign tmr_clr     = (state_q != state_d);

   evpack_wait_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .count (tmr_cnt)
   );

   evpack_src_sel #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .IW      (IW)
   ) u_sel (
      .sel            (idx_q),
      .pop_en         (pop_en),
      .src_word       (src_word),
      .src_word_avail (src_word_avail),
      .src_word_eof   (src_word_eof),
      .sel_word       (sel_word),
      .sel_avail      (sel_avail),
      .sel_eof        (sel_eof),
      .src_pop        (src_pop)
   );

   always_comb begin
      state_d   = state_q;
      idx_d     = idx_q;
      mask_d    = mask_q;
      evt_d     = evt_q;
      pop_en    = 1'b0;
      rec_valid = 1'b0;
      rec_data  = '0;
      unique case (state_q)
         PK_IDLE: begin
            if (|src_frame_vld) state_d = PK_SETTLE;
         end
         PK_SETTLE: begin
            if (settle_done) state_d = PK_GATHER;
         end
         PK_GATHER: begin
            if (all_vld || gather_tmo) begin
               mask_d  = src_frame_vld;
               state_d = PK_BEGIN;
            end
         end
         PK_BEGIN: begin
            rec_valid = 1'b1;
            rec_data  = BEGIN_MARK[DATA_W-1:0];
            if (rec_ready) state_d = PK_HEAD;
         end
         PK_HEAD: begin
            rec_valid = 1'b1;
            rec_data  = {HDR_TAG[TAG_W-1:0], evt_q};
            if (rec_ready) begin
               idx_d   = '0;
               state_d = PK_SCAN;
            end
         end
         PK_SCAN: begin
            if (mask_q[idx_q]) begin
               rec_valid = sel_avail;
               rec_data  = sel_word;
               pop_en    = sel_avail && rec_ready;
            end
            if (!mask_q[idx_q] || (pop_en && sel_eof)) begin
               if (idx_q == LAST_IDX) state_d = PK_END;
               else                   idx_d   = idx_q + 1'b1;
            end
         end
         PK_END: begin
            rec_valid = 1'b1;
            rec_data  = END_MARK[DATA_W-1:0];
            if (rec_ready) begin
               evt_d   = evt_q + 1'b1;
               state_d = PK_IDLE;
            end
         end
         default: state_d = PK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PK_IDLE;
         idx_q   <= '0;
         mask_q  <= '0;
         evt_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         mask_q  <= mask_d;
         evt_q   <= evt_d;
      end
   end

endmodule

// File: rtl/evpack_chk.sv
module evpack_chk #(
   parameter int unsigned NUM_SRC = 20,
   parameter int unsigned DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_frame_vld,
   input logic [NUM_SRC-1:0] src_pop,
   input logic               rec_ready,
   input logic               rec_valid,
   input logic [DATA_W-1:0]  rec_data
);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!rec_valid && src_pop == '0); // R1
      end
   end

   AST_POP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_pop) |-> (rec_valid && rec_ready)); // R8

   AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_pop)); // R8

   AST_POP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_pop) |-> ((src_pop & ~src_frame_vld) == '0)); // R8

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data))); // R8

endmodule

bind evframe_packer evpack_chk #(
   .NUM_SRC (NUM_SRC),
   .DATA_W  (DATA_W)
) u_evpack_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .src_frame_vld (src_frame_vld),
   .src_pop       (src_pop),
   .rec_ready     (rec_ready),
   .rec_valid     (rec_valid),
   .rec_data      (rec_data)
);

// File: tb/test_evframe_packer.sv
module test_evframe_packer;

   localparam int CLK_PERIOD = 10;
   localparam int NS         = 6;
   localparam int W          = 32;
   localparam int TMO        = 12;
   localparam int LIMIT      = 20000;
   localparam logic [31:0] BM  = 32'hC3C3_1001;
   localparam logic [31:0] EM  = 32'h3C3C_2002;
   localparam logic [15:0] TAG = 16'hB00C;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NS-1:0]   frame_vld = '0;
   logic [NS-1:0]   avail = '0;
   logic [NS-1:0]   eof = '0;
   logic [NS*W-1:0] words = '0;
   logic [NS-1:0]   pop;
   logic            rec_ready = 1'b0;
   logic            rec_valid;
   logic [W-1:0]    rec_data;

   evframe_packer #(
      .NUM_SRC (NS), .DATA_W (W), .EVT_W (16), .SETTLE_CYC (4), .TIMEOUT_CYC (TMO),
      .BEGIN_MARK (BM), .END_MARK (EM), .HDR_TAG (TAG)
   ) i_evframe_packer (
      .clk (clk), .rst_n (rst_n), .src_frame_vld (frame_vld), .src_word_avail (avail),
      .src_word (words), .src_word_eof (eof), .src_pop (pop), .rec_ready (rec_ready),
      .rec_valid (rec_valid), .rec_data (rec_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef logic [32:0] ent_t;
   ent_t        srcq [NS][$];
   logic [31:0] exp_q [$];
   string       tag_q [$];
   int          lat_q [$];

   int checks = 0, fails = 0, cyc = 0, t0 = 0, ends = 0, evt_exp = 0, ready_mode = 0;
   bit in_rec = 1'b0, prev_any = 1'b0, stall_prev = 1'b0;
   logic [31:0] data_prev = '0;
   logic [NS-1:0] pend_pop = '0;

   function automatic logic [31:0] wval(input int s, input int k);
      return {8'hD0, 8'(s), 16'(k * 7 + 1)};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic load(input int s, input int n);
      for (int k = 0; k < n; k++) srcq[s].push_back({(k == n - 1), wval(s, k)});
   endtask

   task automatic push_rec(input logic [NS-1:0] m, input int lens [NS], input int lat);
      exp_q.push_back(BM);                    tag_q.push_back("R4");
      exp_q.push_back({TAG, 16'(evt_exp)});   tag_q.push_back("R5");
      evt_exp++;
      for (int s = 0; s < NS; s++)
         if (m[s])
            for (int k = 0; k < lens[s]; k++) begin
               exp_q.push_back(wval(s, k)); tag_q.push_back("R6");
            end
      exp_q.push_back(EM);                    tag_q.push_back("R9");
      lat_q.push_back(lat);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(negedge clk) begin
      ent_t e;
      logic [31:0] ev;
      string tg;
      bit anyv;
      for (int s = 0; s < NS; s++)
         if (pend_pop[s] && srcq[s].size() > 0) e = srcq[s].pop_front();
      rec_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      for (int s = 0; s < NS; s++) begin
         avail[s]          = (srcq[s].size() > 0);
         words[s*W +: W]   = (srcq[s].size() > 0) ? srcq[s][0][31:0] : '0;
         eof[s]            = (srcq[s].size() > 0) ? srcq[s][0][32] : 1'b0;
         frame_vld[s]      = 1'b0;
         foreach (srcq[s][k]) if (srcq[s][k][32]) frame_vld[s] = 1'b1;
      end
      #1;
      cyc++;
      pend_pop = (rec_valid && rec_ready) ? pop : '0;
      if (rst_n) begin
         anyv = |frame_vld;
         if (anyv && !prev_any) t0 = cyc;
         prev_any = anyv;
         if ((|pop) && !(rec_valid && rec_ready))
            check(1'b0, "R8", 32'(pop), 32'h0);
         if (stall_prev)
            check(rec_valid && rec_data == data_prev, "R8", rec_data, data_prev);
         stall_prev = rec_valid && !rec_ready;
         data_prev  = rec_data;
         if (rec_valid && !in_rec) begin
            in_rec = 1'b1;
            if (lat_q.size() > 0) begin
               int el;
               el = lat_q.pop_front();
               check(cyc - t0 == el, (el == 6) ? "R2" : "R3", 32'(cyc - t0), 32'(el));
            end
         end
         if (rec_valid && rec_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", rec_data, 32'h0);
            end else begin
               ev = exp_q.pop_front();
               tg = tag_q.pop_front();
               check(rec_data == ev, tg, rec_data, ev);
               if (tg == "R9") begin
                  in_rec = 1'b0;
                  ends++;
                  t0 = cyc + 1;
               end
            end
         end
      end
      if (cyc > LIMIT) begin
         check(1'b0, "R4", 32'(cyc), 32'(LIMIT));
         finish_run();
      end
   end

   task automatic wait_idle();
      while (exp_q.size() != 0 || in_rec) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int lens [NS];
      repeat (3) @(negedge clk);
      #2 check(!rec_valid && pop == '0, "R1", {31'h0, rec_valid}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         #2 check(!rec_valid && pop == '0, "R1", 32'(pop), 32'h0);
      end

      // R2: all sources at once, random backpressure
      ready_mode = 1;
      lens = '{1, 3, 2, 4, 1, 2};
      push_rec('1, lens, 6);
      for (int s = 0; s < NS; s++) load(s, lens[s]);
      wait_idle();

      // R3: partial set, timeout path, full throughput
      ready_mode = 0;
      lens = '{0, 2, 0, 0, 3, 0};
      push_rec(6'b010010, lens, 5 + TMO);
      load(1, 2);
      load(4, 3);
      wait_idle();

      // R7: late source excluded, then packed alone
      ready_mode = 1;
      lens = '{2, 0, 3, 0, 0, 0};
      push_rec(6'b000101, lens, 5 + TMO);
      lens = '{0, 0, 0, 0, 0, 3};
      push_rec(6'b100000, lens, 5 + TMO);
      load(0, 2);
      load(2, 3);
      while (!in_rec) @(negedge clk);
      @(negedge clk);
      load(5, 3);
      while (ends < 3) @(negedge clk);
      check(srcq[5].size() == 3, "R7", 32'(srcq[5].size()), 32'd3);
      wait_idle();

      for (int s = 0; s < NS; s++)
         check(srcq[s].size() == 0, "R6", 32'(srcq[s].size()), 32'h0);
      check(lat_q.size() == 0 && !rec_valid, "R9", 32'(lat_q.size()), 32'h0);
      finish_run();
   end

endmodule